// File: doc/BRIEF.md
# Motion Sensor Serial Register Port with Burst Read

This block is the device side of a four-wire serial port on a motion sensor. The host selects the port by pulling the active-low select low and clocks command bytes in MSB first. Each command byte has a direction flag in its top bit and a register address in the low seven bits. A write takes one further byte and commits it to the sensor's register file. A read returns one byte from that file. Reading one reserved address starts a burst instead. The burst streams a frozen copy of seven motion registers back to back, with no address phase between the bytes.

All serial inputs are sampled with the block's own system clock. They pass through a synchronizer and then an edge detector. The register file is reached through a combinational read port and a one-cycle write strobe. The seven motion registers come in on a flat snapshot bus. Their byte order on that bus fixes the order in which they are streamed. A burst can be cut short at any byte by deselecting. When all seven bytes have been sent, the port sends only zeros and ignores everything it receives until it is deselected.

Top module: `motion_burst_port`

## Requirements
- R1: While the select input is high, `miso_oe` is 0 and no register write strobe is issued.
- R2: A command byte with bit 7 = 1 is a write. Bits 6:0 are the address and the next 8 bits are the data. On the sixteenth rising SCLK edge, `reg_wr_en` pulses for exactly one system clock, with the address and data held on `reg_wr_addr` and `reg_wr_data`.
- R3: A command byte with bit 7 = 0 and an address other than `BURST_ADDR` is a read. The register value present at the eighth rising edge is returned MSB first during the next eight SCLK cycles, with `miso_oe` = 1.
- R4: A read of `BURST_ADDR` (default 0x50) starts a burst. Byte k of the burst is `snap_data[8k+7:8k]`, for k = 0 (motion flags) up to k = 6 (peak pixel).
- R5: The snapshot is taken at the eighth rising edge of the burst command. Later changes on `snap_data` do not alter the bytes that are streamed.
- R6: Burst bytes follow one another with no address phase. MOSI is ignored during a burst, so MOSI data never causes a write.
- R7: Raising the select at any point ends the current command, discards any remaining burst bytes and clears the bit count. The next selection then starts with a fresh command byte.
- R8: Once all `BURST_LEN` bytes have been sent, MISO sends only 0 bits. All SCLK and MOSI activity, including a new burst command, is ignored until the select is raised.
- R9: After a completed single read or write, the next command byte can follow within the same selection.
- R10: MISO changes only after a falling SCLK edge. MOSI is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ncs | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock from host, idles high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for MISO (0 = high impedance) |
| reg_rd_addr | output | 7 | Register file read address |
| reg_rd_data | input | 8 | Register file read data (combinational) |
| reg_wr_en | output | 1 | Register write strobe, one clock |
| reg_wr_addr | output | 7 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| snap_data | input | 8*BURST_LEN | Live motion register values, byte 0 first |

## Verification
The bench builds the block with its default parameters: `BURST_LEN` = 7, `BURST_ADDR` = 0x50 and two synchronizer stages. With seven bytes, the bench can run a full burst all the way into the zero-filled lockout and send a second burst command there. It can also cut a burst short after three bytes. With two synchronizer stages, each SCLK half-period of four system clocks leaves room for the output bit to settle before the host samples it. The snapshot bus is overwritten just after each burst command, so the streamed bytes are checked against the frozen copy and not the live values.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_CMD   = 3'd0,
        ST_WDATA = 3'd1,
        ST_RDATA = 3'd2,
        ST_BURST = 3'd3,
        ST_LOCK  = 3'd4
    } port_state_e;

    function automatic logic is_write(input byte_t cmd);
        return cmd[BYTE_W-1];
    endfunction

    function automatic addr_t cmd_addr(input byte_t cmd);
        return cmd[ADDR_W-1:0];
    endfunction

    function automatic logic drives_out(input port_state_e s);
        return (s == ST_RDATA) || (s == ST_BURST) || (s == ST_LOCK);
    endfunction
endpackage

// File: rtl/mbp_edges.sv
module mbp_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ncs_i,
    input  logic sclk_i,
    input  logic mosi_i,
    output logic ncs_o,
    output logic mosi_o,
    output logic sclk_rise_o,
    output logic sclk_fall_o
);
    logic [SYNC_STAGES-1:0] ncs_q;
    logic [SYNC_STAGES-1:0] sclk_q;
    logic [SYNC_STAGES-1:0] mosi_q;
    logic                   sclk_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    ncs_q  <= '1;
                    sclk_q <= '1;
                    mosi_q <= '0;
                end else begin
                    ncs_q  <= ncs_i;
                    sclk_q <= sclk_i;
                    mosi_q <= mosi_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    ncs_q  <= '1;
                    sclk_q <= '1;
                    mosi_q <= '0;
                end else begin
                    ncs_q  <= {ncs_q[SYNC_STAGES-2:0], ncs_i};
                    sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk_i};
                    mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b1;
        else     sclk_prev <= sclk_q[SYNC_STAGES-1];
    end

    assign ncs_o       = ncs_q[SYNC_STAGES-1];
    assign mosi_o      = mosi_q[SYNC_STAGES-1];
    assign sclk_rise_o = !ncs_o &&  sclk_q[SYNC_STAGES-1] && !sclk_prev;
    assign sclk_fall_o = !ncs_o && !sclk_q[SYNC_STAGES-1] &&  sclk_prev;
endmodule

// File: rtl/mbp_snapshot.sv
module mbp_snapshot
    import mbp_pkg::*;
#(
    parameter int BURST_LEN = 7,
    parameter int IDX_W     = $clog2(BURST_LEN + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        capture_i,
    input  logic [BURST_LEN*BYTE_W-1:0] live_i,
    input  logic [IDX_W-1:0]            sel_i,
    output byte_t                       byte_o
);
    byte_t store [BURST_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BURST_LEN; i++) store[i] <= '0;
        end else if (capture_i) begin
            for (int i = 0; i < BURST_LEN; i++) store[i] <= live_i[i*BYTE_W +: BYTE_W];
        end
    end

    // Past the last entry the selector yields zero, which feeds the lockout fill.
    always_comb begin
        byte_o = '0;
        for (int i = 0; i < BURST_LEN; i++) begin
            if (sel_i == IDX_W'(i)) byte_o = store[i];
        end
        if (capture_i) byte_o = live_i[BYTE_W-1:0];
    end
endmodule

// File: rtl/mbp_txshift.sv
module mbp_txshift
    import mbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear_i,
    input  logic  load_i,
    input  byte_t load_val_i,
    input  logic  shift_i,
    output logic  miso_o
);
    byte_t tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            miso_o <= 1'b0;
        end else if (clear_i) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= load_val_i;
        end else if (shift_i) begin
            miso_o <= tx_q[BYTE_W-1];
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/motion_burst_port.sv
module motion_burst_port
    import mbp_pkg::*;
#(
    parameter logic [6:0] BURST_ADDR  = 7'h50,
    parameter int         BURST_LEN   = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ncs,
    input  logic                        sclk,
    input  logic                        mosi,
    output logic                        miso,
    output logic                        miso_oe,
    output logic [6:0]                  reg_rd_addr,
    input  logic [7:0]                  reg_rd_data,
    output logic                        reg_wr_en,
    output logic [6:0]                  reg_wr_addr,
    output logic [7:0]                  reg_wr_data,
    input  logic [BURST_LEN*8-1:0]      snap_data
);
    localparam int IDX_W = $clog2(BURST_LEN + 1);

    logic ncs_s, mosi_s, sclk_rise, sclk_fall;

    port_state_e       state;
    logic [2:0]        bit_cnt;
    logic [ADDR_W-1:0] rx_q;
    logic [IDX_W-1:0]  byte_idx;
    addr_t             wr_addr_q;
    byte_t             wr_data_q;
    logic              wr_en_q;
    logic              oe_q;

    byte_t            cmd_now;
    logic             last_bit;
    logic             is_burst_cmd;
    logic             snap_capture;
    logic [IDX_W-1:0] snap_sel;
    byte_t            snap_byte;
    logic             tx_load;
    byte_t            tx_val;
    logic             tx_shift;

    mbp_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk         (clk),
        .rst         (rst),
        .ncs_i       (ncs),
        .sclk_i      (sclk),
        .mosi_i      (mosi),
        .ncs_o       (ncs_s),
        .mosi_o      (mosi_s),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall)
    );

    assign cmd_now      = {rx_q, mosi_s};
    assign last_bit     = sclk_rise && (bit_cnt == 3'd7);
    assign is_burst_cmd = !is_write(cmd_now) && (cmd_addr(cmd_now) == BURST_ADDR);
    assign snap_capture = last_bit && (state == ST_CMD) && is_burst_cmd;
    assign snap_sel     = snap_capture ? '0 : IDX_W'(byte_idx + 1'b1);

    mbp_snapshot #(.BURST_LEN(BURST_LEN), .IDX_W(IDX_W)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .capture_i (snap_capture),
        .live_i    (snap_data),
        .sel_i     (snap_sel),
        .byte_o    (snap_byte)
    );

    always_comb begin
        tx_load = 1'b0;
        tx_val  = snap_byte;
        if (last_bit) begin
            if (state == ST_CMD && !is_write(cmd_now)) begin
                tx_load = 1'b1;
                if (!is_burst_cmd) tx_val = reg_rd_data;
            end else if (state == ST_BURST) begin
                tx_load = 1'b1;
            end
        end
    end

    assign tx_shift = sclk_fall && drives_out(state);

    mbp_txshift u_tx (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (ncs_s),
        .load_i     (tx_load),
        .load_val_i (tx_val),
        .shift_i    (tx_shift),
        .miso_o     (miso)
    );

    always_ff @(posedge clk) begin
        if (rst || ncs_s) begin
            state    <= ST_CMD;
            bit_cnt  <= '0;
            byte_idx <= '0;
            oe_q     <= 1'b0;
            wr_en_q  <= 1'b0;
            if (rst) begin
                rx_q      <= '0;
                wr_addr_q <= '0;
                wr_data_q <= '0;
            end
        end else begin
            wr_en_q <= 1'b0;
            if (sclk_rise && state != ST_LOCK) begin
                rx_q    <= cmd_now[ADDR_W-1:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    unique case (state)
                        ST_CMD: begin
                            if (is_write(cmd_now)) begin
                                state     <= ST_WDATA;
                                wr_addr_q <= cmd_addr(cmd_now);
                            end else if (is_burst_cmd) begin
                                state    <= ST_BURST;
                                byte_idx <= '0;
                                oe_q     <= 1'b1;
                            end else begin
                                state <= ST_RDATA;
                                oe_q  <= 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            wr_en_q   <= 1'b1;
                            wr_data_q <= cmd_now;
                            state     <= ST_CMD;
                        end
                        ST_RDATA: begin
                            state <= ST_CMD;
                            oe_q  <= 1'b0;
                        end
                        ST_BURST: begin
                            if (byte_idx == IDX_W'(BURST_LEN - 1)) state <= ST_LOCK;
                            else byte_idx <= IDX_W'(byte_idx + 1'b1);
                        end
                        default: state <= ST_LOCK;
                    endcase
                end
            end
        end
    end

    assign reg_rd_addr = cmd_addr(cmd_now);
    assign reg_wr_en   = wr_en_q;
    assign reg_wr_addr = wr_addr_q;
    assign reg_wr_data = wr_data_q;
    assign miso_oe     = oe_q;
endmodule

// File: rtl/mbp_checker.sv
module mbp_checker
    import mbp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        ncs_s,
    input logic        sclk_fall,
    input port_state_e state,
    input logic [2:0]  bit_cnt,
    input logic        miso,
    input logic        miso_oe,
    input logic        reg_wr_en
);
    a_r1_oe_off_deselected: assert property (@(posedge clk) disable iff (rst)
        ncs_s |=> !miso_oe);

    a_r1_no_write_deselected: assert property (@(posedge clk) disable iff (rst)
        $past(ncs_s) |-> !reg_wr_en);

    a_r2_write_single_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    a_r7_select_clears: assert property (@(posedge clk) disable iff (rst)
        ncs_s |=> (state == ST_CMD && bit_cnt == 3'd0));

    a_r8_lock_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && sclk_fall) |=> (miso == 1'b0));

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && !ncs_s) |=> (state == ST_LOCK));

    a_r10_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(miso) |-> $past(sclk_fall));
endmodule

bind motion_burst_port mbp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ncs_s     (ncs_s),
    .sclk_fall (sclk_fall),
    .state     (state),
    .bit_cnt   (bit_cnt),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .reg_wr_en (reg_wr_en)
);

// File: tb/tb_motion_burst_port.sv
module tb_motion_burst_port;
    localparam int BLEN = 7;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ncs = 1'b1;
    logic sclk = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;
    logic [6:0] reg_rd_addr, reg_wr_addr;
    logic [7:0] reg_rd_data, reg_wr_data;
    logic reg_wr_en;
    logic [BLEN*8-1:0] snap_data = '0;

    logic [7:0] mem [128];
    int checks = 0;
    int failures = 0;
    int wr_count = 0;
    logic [6:0] last_wr_addr = '0;
    logic [7:0] last_wr_data = '0;
    bit done = 0;

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t exp_q[$];
    logic [7:0] got_q[$];

    always #5 clk = ~clk;

    motion_burst_port dut (
        .clk(clk), .rst(rst), .ncs(ncs), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .snap_data(snap_data)
    );

    assign reg_rd_data = mem[reg_rd_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_wr_addr] <= reg_wr_data;
            last_wr_addr     <= reg_wr_addr;
            last_wr_data     <= reg_wr_data;
            wr_count         <= wr_count + 1;
        end
    end

    // Monitor: pops each received byte against the next expected byte.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && got_q.size() > 0) begin
            exp_t e;
            logic [7:0] g;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            checks++;
            if (g !== e.v) begin
                failures++;
                $display("FAIL %s: got %02h expected %02h", e.tag, g, e.v);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic cmd_byte(input logic [7:0] tx);
        logic [7:0] r;
        xfer_bits(tx, 8, r);
    endtask

    task automatic data_byte(input logic [7:0] tx);
        logic [7:0] r;
        xfer_bits(tx, 8, r);
        got_q.push_back(r);
    endtask

    task automatic select_port();
        @(negedge clk);
        ncs = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic deselect_port();
        @(negedge clk);
        ncs = 1'b1;
        sclk = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    localparam logic [BLEN*8-1:0] SNAP_A = {8'h3F, 8'h9C, 8'h01, 8'h44, 8'hFE, 8'h12, 8'h80};
    localparam logic [BLEN*8-1:0] SNAP_B = {8'h07, 8'h06, 8'h05, 8'h04, 8'hC3, 8'hB2, 8'hA1};

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 1);
        mem[7'h05] = 8'h3C;
        mem[7'h21] = 8'h81;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset and deselected state
        check("R1 oe at reset", 32'(miso_oe), 0);
        check("R1 no write at reset", 32'(reg_wr_en), 0);

        // R2, R9: write then read back in one selection
        select_port();
        cmd_byte(8'h80 | 8'h12);
        cmd_byte(8'hA5);
        repeat (2) @(negedge clk);
        check("R2 write count", 32'(wr_count), 1);
        check("R2 write addr", 32'(last_wr_addr), 32'h12);
        check("R2 write data", 32'(last_wr_data), 32'hA5);
        cmd_byte(8'h12);
        check("R3 oe during read", 32'(miso_oe), 1);
        data_byte(8'h00);
        expect_byte(8'hA5, "R9 read after write");
        // R3: plain read of two registers
        cmd_byte(8'h05);
        data_byte(8'h00);
        expect_byte(8'h3C, "R3 read 0x05");
        cmd_byte(8'h21);
        data_byte(8'h00);
        expect_byte(8'h81, "R3 read 0x21");
        // R10: MISO holds with SCLK high after the last rising edge
        repeat (HALF) @(negedge clk);
        check("R10 miso held", 32'(miso), 1);
        deselect_port();
        check("R7 oe after deselect", 32'(miso_oe), 0);

        // R4, R5, R6, R8: full burst with live values changing and junk on MOSI
        snap_data = SNAP_A;
        select_port();
        cmd_byte(8'h50);
        snap_data = SNAP_B;
        for (int k = 0; k < BLEN; k++) begin
            data_byte(8'hFF);
            expect_byte(SNAP_A[k*8 +: 8], k == 0 ? "R4 burst order" : "R5 frozen snapshot");
        end
        data_byte(8'h50);
        expect_byte(8'h00, "R8 zero fill");
        data_byte(8'h50);
        expect_byte(8'h00, "R8 second burst ignored");
        check("R6 no write from burst MOSI", 32'(wr_count), 1);
        deselect_port();
        check("R7 oe after burst", 32'(miso_oe), 0);

        // R7: early termination after three bytes
        select_port();
        cmd_byte(8'h50);
        for (int k = 0; k < 3; k++) begin
            data_byte(8'h00);
            expect_byte(SNAP_B[k*8 +: 8], "R7 partial burst");
        end
        deselect_port();
        select_port();
        cmd_byte(8'h05);
        data_byte(8'h00);
        expect_byte(8'h3C, "R7 read after early exit");
        deselect_port();

        // R7: abort in the middle of a command byte
        select_port();
        begin
            logic [7:0] r;
            xfer_bits(8'hFF, 3, r);
        end
        deselect_port();
        select_port();
        cmd_byte(8'h21);
        data_byte(8'h00);
        expect_byte(8'h81, "R7 read after mid-byte abort");
        deselect_port();
        check("R7 no stray write", 32'(wr_count), 1);

        repeat (10) @(negedge clk);
        check("scoreboard drained exp", 32'(exp_q.size()), 0);
        check("scoreboard drained got", 32'(got_q.size()), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule